// File: doc/BRIEF.md
# Track Bit Strobe Replayer

This block plays back decoded stripe bits as three strobe/data pairs, one pair per track, and drives a shared active-low media-detect line. Bits come from a track buffer, one per accepted `bit_vld`/`bit_rdy` transfer, so the replay pace comes from a programmable bit period and not from the card speed. Each track first searches its stream for a run of six zero bits. That run, and everything before it, is used only for synchronisation and is never replayed. The first track to find its run pulls media detect low. A fixed start delay (3 µs at the default clock) then passes before any track begins to strobe.

Each replayed bit occupies one slot. The data line is set at the start of the slot, with high meaning a zero bit. One cycle later the strobe falls and stays low for half the slot. A rate pin doubles the slot length for slow receivers. While the sleep input is high, every output is held high and all synchronisation state is discarded.

Top module: `strobe_replay`

## Requirements
- R1: While reset is held, every strobe, every data line and media detect are high.
- R2: Media detect goes low in the cycle after a track accepts its sixth consecutive zero bit. A one bit restarts that track's count. Once low, media detect stays low until sleep.
- R3: No bit is replayed before its track has locked. Neither the six-zero run nor any bit ahead of it is replayed. Before lock, that track's strobe and data stay high.
- R4: A replayed zero bit drives data high. A replayed one bit drives data low.
- R5: Each strobe idles high. It falls one cycle after its data line is loaded and stays low for floor(P/2) cycles, where P is the slot length. At full rate P equals `bit_period`, and a `bit_period` below 3 is treated as 3.
- R6: Data is stable in the cycle before the strobe falls, through the whole low phase, and in the cycle in which the strobe rises.
- R7: The first strobe falls no earlier than DLY+2 cycles after media detect falls, where DLY = CLK_MHZ*DLY_NS/1000 (375 by default). When a bit is already waiting, the first strobe falls exactly DLY+2 cycles after media detect falls.
- R8: When `full_rate` is low, P is twice the clamped `bit_period`. The rate is captured for each bit when that bit is accepted, so a change of the pin affects only bits taken after the change.
- R9: While `sleep` is high, all outputs are high in the same cycle and `bit_rdy` is low. After sleep, a track must lock again before it replays anything.
- R10: Each track replays exactly the bits that follow its own six-zero run, in stream order, at its own pace. A bit is consumed only in a cycle where both `bit_vld` and `bit_rdy` are high for that track.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Power-down indicator; forces outputs high and clears state |
| full_rate | input | 1 | 1: slot = bit_period, 0: slot = 2*bit_period |
| bit_period | input | 16 | Replay bit period in clock cycles (minimum 3 applied) |
| bit_vld | input | 3 | Per-track bit offered by the buffer |
| bit_val | input | 3 | Per-track bit value |
| bit_rdy | output | 3 | Per-track bit taken this cycle when valid |
| strb_n | output | 3 | Per-track strobe, low during the sample window |
| dat | output | 3 | Per-track data, high for a zero bit |
| media_n | output | 1 | Active-low media detect (1 = released) |

## Verification
Two events can land on the same clock edge: a rate change on `full_rate`, and the acceptance of the next bit at a slot boundary. The bench toggles the rate pin at random cycles while all three tracks replay back to back. It records the rate seen at each bit's acceptance and measures every strobe's low width against the slot length derived from that recorded rate. A second collision is sleep arriving while a strobe is low. The bench checks that all outputs go high in that same cycle and that nothing is replayed afterwards until a fresh six-zero run appears.

// File: rtl/strobe_replay.sv
module strobe_replay #(
  parameter int NTRK       = 3,
  parameter int PW         = 16,
  parameter int SYNC_ZEROS = 6,
  parameter int CLK_MHZ    = 125,
  parameter int DLY_NS     = 3000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep,
  input  logic            full_rate,
  input  logic [PW-1:0]   bit_period,
  input  logic [NTRK-1:0] bit_vld,
  input  logic [NTRK-1:0] bit_val,
  output logic [NTRK-1:0] bit_rdy,
  output logic [NTRK-1:0] strb_n,
  output logic [NTRK-1:0] dat,
  output logic            media_n
);
  localparam int DLY_CYC = CLK_MHZ * DLY_NS / 1000;
  localparam int DW      = $clog2(DLY_CYC + 1);
  localparam int ZW      = $clog2(SYNC_ZEROS + 1);
  localparam int CW      = PW + 1;

  logic [NTRK-1:0] locked;
  logic [DW-1:0]   dly;
  logic            start_ok;

  wire [PW-1:0] base    = (bit_period < PW'(3)) ? PW'(3) : bit_period;
  wire [CW-1:0] per_new = full_rate ? {1'b0, base} : {base, 1'b0};

  assign start_ok = (dly == DW'(DLY_CYC));
  assign media_n  = sleep | ~(|locked);

  always_ff @(posedge clk) begin
    if (!rst_n || sleep)
      dly <= '0;
    else if (|locked && !start_ok)
      dly <= dly + DW'(1);
  end

  AST_NO_EARLY_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ok |-> &strb_n);                                            // R7
  AST_MEDIA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!media_n && !sleep) |=> (!media_n || sleep));                     // R2

  for (genvar i = 0; i < NTRK; i++) begin : g_trk
    logic [ZW-1:0] zc;
    logic          lk;
    logic          act;
    logic          d;
    logic [CW-1:0] cnt;
    logic [CW-1:0] per;

    wire [CW-1:0] half     = per >> 1;
    wire          slot_end = !act || (cnt == per - CW'(1));
    wire          take     = bit_vld[i] && bit_rdy[i];

    assign locked[i]  = lk;
    assign bit_rdy[i] = !sleep && (!lk || (start_ok && slot_end));
    assign strb_n[i]  = sleep | ~(act && (cnt != '0) && (cnt <= half));
    assign dat[i]     = sleep | d;

    always_ff @(posedge clk) begin
      if (!rst_n || sleep) begin
        zc  <= '0;
        lk  <= 1'b0;
        act <= 1'b0;
        d   <= 1'b1;
        cnt <= '0;
        per <= CW'(3);
      end else if (!lk) begin
        if (take) begin
          if (!bit_val[i]) begin
            if (zc == ZW'(SYNC_ZEROS - 1)) begin
              lk <= 1'b1;
              zc <= '0;
            end else begin
              zc <= zc + ZW'(1);
            end
          end else begin
            zc <= '0;
          end
        end
      end else if (take) begin
        d   <= ~bit_val[i];
        per <= per_new;
        cnt <= '0;
        act <= 1'b1;
      end else if (act) begin
        if (cnt == per - CW'(1))
          act <= 1'b0;
        else
          cnt <= cnt + CW'(1);
      end
    end

    AST_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && $fell(strb_n[i])) |-> $stable(dat[i]));               // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_n[i] && !sleep) |=> ($stable(dat[i]) || sleep));         // R6
    AST_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !lk |-> (strb_n[i] && dat[i]));                                  // R3
  end
endmodule

// File: tb/tb_strobe_replay.sv
module tb_strobe_replay;
  localparam int NT  = 3;
  localparam int DLY = 375;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic        full_rate = 1'b1;
  logic [15:0] bit_period = 16'd10;
  logic [2:0]  bit_vld = '0;
  logic [2:0]  bit_val = '0;
  wire  [2:0]  bit_rdy, strb_n, dat;
  wire         media_n;

  strobe_replay dut (.clk(clk), .rst_n(rst_n), .sleep(sleep), .full_rate(full_rate),
    .bit_period(bit_period), .bit_vld(bit_vld), .bit_val(bit_val),
    .bit_rdy(bit_rdy), .strb_n(strb_n), .dat(dat), .media_n(media_n));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int gap_pct = 0;
  bit rate_toggle = 0;
  bit src[NT][$];
  bit orig[NT][$];
  bit exp_b[NT][$];
  int exp_p[NT][$];
  bit fire[NT], fr_f[NT], lk[NT], prv_s[NT], prv_d[NT];
  int zr[NT], lowc[NT], cur_p[NT], nstb[NT];
  int media_fall, first_fall;
  bit prv_m;

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int per_of(bit fr, int bp);
    int b = (bp < 3) ? 3 : bp;
    return fr ? b : 2 * b;
  endfunction

  function automatic int emit_count(input bit s[$]);
    int z = 0;
    for (int k = 0; k < s.size(); k++) begin
      if (s[k] == 1'b0) begin
        z++;
        if (z == 6) return s.size() - k - 1;
      end else z = 0;
    end
    return 0;
  endfunction

  task automatic clr_model();
    for (int t = 0; t < NT; t++) begin
      zr[t] = 0; lk[t] = 0; exp_b[t].delete(); exp_p[t].delete();
      fire[t] = 0; lowc[t] = 0; prv_s[t] = 1; prv_d[t] = 1; nstb[t] = 0;
    end
    media_fall = -1; first_fall = -1; prv_m = 1;
  endtask

  task automatic do_cycle();
    bit b, s, d;
    int p;
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    for (int t = 0; t < NT; t++) begin
      if (fire[t]) begin
        b = src[t].pop_front();
        if (lk[t]) begin
          exp_b[t].push_back(b);
          exp_p[t].push_back(per_of(fr_f[t], int'(bit_period)));
        end else if (b == 1'b0) begin
          zr[t]++;
          if (zr[t] == 6) lk[t] = 1;
        end else zr[t] = 0;
      end
    end
    if (sleep) begin
      chk(strb_n == 3'b111 && dat == 3'b111 && media_n && bit_rdy == 3'b000,
          "R9 outputs high in sleep", {strb_n, dat, media_n, bit_rdy}, 10'h3F8);
      clr_model();
      bit_vld = '0;
      return;
    end
    chk(media_n == !(lk[0] | lk[1] | lk[2]), "R2 media detect", media_n,
        !(lk[0] | lk[1] | lk[2]));
    if (prv_m && !media_n) media_fall = cyc;
    prv_m = media_n;
    for (int t = 0; t < NT; t++) begin
      s = strb_n[t]; d = dat[t];
      if (!lk[t]) chk(s && d, "R3 quiet before lock", {s, d}, 3);
      if (prv_s[t] && !s) begin
        nstb[t]++;
        if (exp_b[t].size() == 0) begin
          chk(0, "R3 unexpected strobe", t, -1);
        end else begin
          b = exp_b[t].pop_front(); p = exp_p[t].pop_front();
          chk(d == ~b, "R4 data polarity", d, ~b);
          chk(d == prv_d[t], "R6 data setup", d, prv_d[t]);
          cur_p[t] = p;
        end
        lowc[t] = 1;
        if (first_fall < 0) begin
          first_fall = cyc;
          chk(media_fall >= 0 && cyc - media_fall >= DLY + 2, "R7 start delay",
              cyc - media_fall, DLY + 2);
        end
      end else if (!s) begin
        lowc[t]++;
        chk(d == prv_d[t], "R6 data hold low", d, prv_d[t]);
      end else if (!prv_s[t] && s) begin
        chk(d == prv_d[t], "R6 data hold rise", d, prv_d[t]);
        chk(lowc[t] == cur_p[t] / 2, (cur_p[t] == per_of(1, int'(bit_period))) ?
            "R5 low width" : "R8 half-rate low width", lowc[t], cur_p[t] / 2);
      end
      prv_s[t] = s; prv_d[t] = d;
    end
    for (int t = 0; t < NT; t++) begin
      if (src[t].size() > 0 && ($urandom % 100) >= gap_pct) begin
        bit_vld[t] = 1'b1; bit_val[t] = src[t][0];
      end else begin
        bit_vld[t] = 1'b0; bit_val[t] = 1'b0;
      end
      fire[t] = bit_vld[t] & bit_rdy[t];
      fr_f[t] = full_rate;
    end
  endtask

  task automatic run_phase(bit count_check);
    bit busy;
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      if (rate_toggle && ($urandom % 40) == 0) full_rate = ~full_rate;
      do_cycle();
      busy = 0;
      for (int t = 0; t < NT; t++)
        if (src[t].size() > 0 || exp_b[t].size() > 0 || !strb_n[t]) busy = 1;
      if (!busy && k > DLY + 10) break;
    end
    for (int k = 0; k < 40; k++) begin @(negedge clk); do_cycle(); end
    if (count_check)
      for (int t = 0; t < NT; t++)
        chk(nstb[t] == emit_count(orig[t]) && src[t].size() == 0,
            "R10 per-track strobe count", nstb[t], emit_count(orig[t]));
  endtask

  task automatic go_sleep();
    sleep = 1'b1;
    for (int k = 0; k < 4; k++) begin @(negedge clk); do_cycle(); end
    for (int t = 0; t < NT; t++) begin src[t].delete(); orig[t].delete(); end
  endtask

  task automatic wake();
    for (int t = 0; t < NT; t++) src[t] = orig[t];
    sleep = 1'b0;
  endtask

  initial begin
    int mode, pre, pay;
    void'($urandom(32'd1234));
    clr_model();
    for (int k = 0; k < 5; k++) @(negedge clk);
    chk(strb_n == 3'b111 && dat == 3'b111 && media_n == 1'b1, "R1 reset state",
        {strb_n, dat, media_n}, 7'h7F);
    rst_n = 1'b1;

    // directed: exact start delay and polarity on track 0
    for (int k = 0; k < 6; k++) orig[0].push_back(1'b0);
    orig[0].push_back(1); orig[0].push_back(0); orig[0].push_back(1);
    orig[0].push_back(1); orig[0].push_back(0);
    wake();
    run_phase(1);
    chk(first_fall - media_fall == DLY + 2, "R7 exact start delay",
        first_fall - media_fall, DLY + 2);

    // directed: a one breaks the zero run (R2, R3); half rate on track 2 (R8)
    go_sleep();
    full_rate = 1'b0; bit_period = 16'd7;
    for (int k = 0; k < 5; k++) orig[1].push_back(1'b0);
    orig[1].push_back(1'b1);
    for (int k = 0; k < 6; k++) orig[1].push_back(1'b0);
    orig[1].push_back(1'b1); orig[1].push_back(1'b0);
    for (int k = 0; k < 6; k++) orig[2].push_back(1'b0);
    for (int k = 0; k < 8; k++) orig[2].push_back(k[0]);
    wake();
    run_phase(1);

    // directed: period below the floor (R5)
    go_sleep();
    full_rate = 1'b1; bit_period = 16'd1;
    for (int k = 0; k < 6; k++) orig[0].push_back(1'b0);
    for (int k = 0; k < 10; k++) orig[0].push_back(k[1]);
    wake();
    run_phase(1);

    // random phases, all tracks, rate pin toggling (R8, R10)
    for (int ph = 0; ph < 6; ph++) begin
      go_sleep();
      case ($urandom % 3)
        0: bit_period = 16'd10;
        1: bit_period = 16'd7;
        default: bit_period = 16'd2;
      endcase
      full_rate = 1'($urandom % 2);
      gap_pct = (ph % 2) ? 25 : 0;
      rate_toggle = 1;
      for (int t = 0; t < NT; t++) begin
        mode = $urandom % 3; pre = $urandom % 9; pay = 10 + $urandom % 30;
        for (int k = 0; k < pre; k++) orig[t].push_back((k % 3 == 2) ? 1'b1 : 1'($urandom % 2));
        if (mode != 0) for (int k = 0; k < 6; k++) orig[t].push_back(1'b0);
        for (int k = 0; k < pay; k++)
          orig[t].push_back((mode == 0 && k % 3 == 2) ? 1'b1 : 1'($urandom % 2));
      end
      wake();
      run_phase(1);
    end
    rate_toggle = 0; gap_pct = 0;

    // sleep while a strobe is low, then no relock (R9)
    go_sleep();
    full_rate = 1'b1; bit_period = 16'd10;
    for (int k = 0; k < 6; k++) orig[0].push_back(1'b0);
    for (int k = 0; k < 40; k++) orig[0].push_back(1'($urandom % 2));
    wake();
    for (int k = 0; k < 5000 && !(nstb[0] >= 3 && !prv_s[0]); k++) begin
      @(negedge clk); do_cycle();
    end
    chk(nstb[0] >= 3, "R9 replay reached before sleep", nstb[0], 3);
    go_sleep();
    for (int k = 0; k < 30; k++) orig[0].push_back(1'b1);
    wake();
    run_phase(1);
    chk(nstb[0] == 0 && media_n == 1'b1, "R9 relock needed after sleep",
        nstb[0] + (media_n ? 0 : 100), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule